// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node of a distributed shared-memory system with up to `N_NODES` caching nodes. For each of `N_BLOCKS` tracked memory blocks it keeps a directory entry: a coherence state and a node bit vector. In the Shared state the vector lists every sharer. In the Modified state the vector has exactly one bit set, and that bit names the owner. Nodes send read misses, write misses and writebacks to the home node. The controller answers with point-to-point messages on its outgoing channel: a data reply to the requester, an invalidate to each other sharer, or a fetch / fetch-invalidate to the current owner.

Only the nodes recorded in the entry are contacted. Nothing is broadcast. The controller serves one transaction at a time. While a transaction is open, including the time spent collecting invalidation acknowledgements, the request channel is held not-ready, so a later request to the same block waits. Data returned by an owner is flagged to the memory array through a write strobe. The memory array itself, the network and the node caches are outside the block.

The controller is a state machine with seven named states:
- IDLE accepts a request and decodes it against the entry.
- SEND_INV issues one invalidate per handshake.
- WAIT_ACK waits for the acknowledgement counter to reach zero.
- FETCH issues a fetch or a fetch-invalidate.
- WAIT_DATA waits for the owner's data.
- REPLY sends the data reply and commits the new entry.
- WBACK commits a writeback.

The transitions are:
- IDLE→REPLY for a read to Invalid or Shared, a write to Invalid, or a write by the sole sharer.
- IDLE→SEND_INV for a write to a Shared block that has other sharers.
- IDLE→FETCH for any miss to a Modified block.
- IDLE→WBACK for a writeback.
- SEND_INV→WAIT_ACK on the last invalidate.
- WAIT_ACK→REPLY when no acknowledgement is outstanding.
- FETCH→WAIT_DATA on the handshake.
- WAIT_DATA→REPLY on the owner's data.
- REPLY→IDLE and WBACK→IDLE.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry is Invalid with an empty vector, `req_ready` is 1, and `msg_valid`, `ack_ready` and `mem_wr_valid` are 0.
- R2: A read miss (`req_kind`=0) to an Invalid or Shared block produces exactly one message, a data reply (`msg_kind`=0) to the requester. The requester is added to the vector and the entry becomes Shared.
- R3: A read miss to a Modified block sends a fetch (`msg_kind`=2) to the owner. When the owner's data arrives (`ack_kind`=1 from that owner for that block), the controller pulses `mem_wr_valid` once and then sends a data reply. The owner and the requester both become sharers.
- R4: A write miss (`req_kind`=1) to an Invalid block produces only a data reply, and the requester becomes the Modified owner.
- R5: A write miss to a Shared block sends exactly one invalidate (`msg_kind`=1) to each recorded sharer other than the requester, and never one to the requester. The data reply follows only after one acknowledgement (`ack_kind`=0) per invalidate has been consumed. The requester becomes the Modified owner.
- R6: A write miss to a Modified block sends a fetch-invalidate (`msg_kind`=3) to the owner, pulses `mem_wr_valid` once on the returned data, and then replies. The requester becomes the new owner.
- R7: A writeback (`req_kind`=2) from the recorded owner of a Modified block pulses `mem_wr_valid` once and sets the entry to Invalid with an empty vector. No message is sent.
- R8: A writeback from a node that is not the owner, or to a block that is not Modified, causes no memory write and no message, and leaves the entry unchanged.
- R9: From the acceptance of a request until its transaction finishes (reply sent or writeback committed), `req_ready` stays 0. No request is taken while acknowledgements are outstanding.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the outgoing message holds its node, address and kind into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request from a node is present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_node | input | NW | Requesting node ID |
| req_addr | input | AW | Block address |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| ack_valid | input | 1 | Response from a node is present |
| ack_ready | output | 1 | Controller consumes a response this cycle |
| ack_node | input | NW | Responding node ID |
| ack_addr | input | AW | Block address of the response |
| ack_kind | input | 1 | 0 invalidation acknowledgement, 1 fetched data |
| msg_valid | output | 1 | Outgoing message is present |
| msg_ready | input | 1 | Network takes the outgoing message |
| msg_node | output | NW | Destination node |
| msg_addr | output | AW | Block address of the message |
| msg_kind | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-invalidate |
| mem_wr_valid | output | 1 | Memory must be updated for `mem_wr_addr` this cycle |
| mem_wr_addr | output | AW | Block address of the memory update |

## Verification
A request is taken on the clock edge where `req_valid` and `req_ready` are both 1. The first outgoing message of that transaction appears in the following cycle. After that, one invalidate leaves per accepted outgoing handshake. The reply appears in the cycle after the last acknowledgement is consumed, because the outstanding count is registered. It also appears in the cycle after the owner's data is taken. `mem_wr_valid` is high in the same cycle as the fetched-data handshake, and in the cycle right after a writeback is accepted.

The bench drives inputs on the falling edge, samples every output 1 ns later, and follows handshakes one cycle at a time. Backpressure and acknowledgement gaps come from fixed cycle patterns, so every message is compared in the cycle it is handed over.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [1:0] {
        DS_INV = 2'd0,
        DS_SHR = 2'd1,
        DS_MOD = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } rq_e;

    localparam logic AK_INV  = 1'b0;
    localparam logic AK_DATA = 1'b1;

    typedef enum logic [1:0] {
        OM_DATA      = 2'd0,
        OM_INV       = 2'd1,
        OM_FETCH     = 2'd2,
        OM_FETCH_INV = 2'd3
    } om_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INV,
        S_WAIT_ACK,
        S_FETCH,
        S_WAIT_DATA,
        S_REPLY,
        S_WB
    } fsm_e;

endpackage

// File: rtl/dirc_pick.sv
module dirc_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dirc_tally.sv
module dirc_tally #(
    parameter int MAXC = 8,
    parameter int CW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && !dec) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign zero  = (cnt_q == '0);

    // an acknowledgement never arrives without an invalidate out
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (cnt_q != '0));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXC));
endmodule

// File: rtl/dirc_store.sv
module dirc_store
    import dirc_pkg::*;
#(
    parameter int N_NODES  = 8,
    parameter int N_BLOCKS = 16,
    parameter int AW       = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      rd_addr,
    output dstate_e            rd_st,
    output logic [N_NODES-1:0] rd_vec,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  dstate_e            wr_st,
    input  logic [N_NODES-1:0] wr_vec
);
    dstate_e            st_q  [N_BLOCKS];
    logic [N_NODES-1:0] vec_q [N_BLOCKS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < N_BLOCKS; b++) begin
                st_q[b]  <= DS_INV;
                vec_q[b] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_addr]  <= wr_st;
            vec_q[wr_addr] <= wr_vec;
        end
    end

    assign rd_st  = st_q[rd_addr];
    assign rd_vec = vec_q[rd_addr];

    // entry invariants on every commit
    assert_mod_single_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_st == DS_MOD) |-> $onehot0(wr_vec) && (wr_vec != '0));

    assert_inv_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_st == DS_INV) |-> (wr_vec == '0));

    assert_shr_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_st == DS_SHR) |-> (wr_vec != '0));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dirc_pkg::*;
#(
    parameter  int N_NODES  = 8,
    parameter  int N_BLOCKS = 16,
    localparam int NW       = (N_NODES > 1) ? $clog2(N_NODES) : 1,
    localparam int AW       = (N_BLOCKS > 1) ? $clog2(N_BLOCKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [NW-1:0] req_node,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_kind,
    input  logic          ack_valid,
    output logic          ack_ready,
    input  logic [NW-1:0] ack_node,
    input  logic [AW-1:0] ack_addr,
    input  logic          ack_kind,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic [NW-1:0] msg_node,
    output logic [AW-1:0] msg_addr,
    output logic [1:0]    msg_kind,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr
);
    localparam int CW = $clog2(N_NODES + 1);

    fsm_e st_q, st_d;

    // directory lookup and commit
    dstate_e            rd_st;
    logic [N_NODES-1:0] rd_vec;
    logic               wr_en;
    dstate_e            wr_st;
    logic [N_NODES-1:0] wr_vec;

    // open transaction
    logic [NW-1:0]      t_node;
    logic [AW-1:0]      t_addr;
    dstate_e            nxt_st_q;
    logic [N_NODES-1:0] nxt_vec_q;
    logic [N_NODES-1:0] inv_left_q;
    logic               finv_q;
    logic               wbok_q;
    logic [NW-1:0]      owner_q;

    // decode of an incoming request
    logic [N_NODES-1:0] req_oh;
    fsm_e               dec_fsm;
    dstate_e            dec_nst;
    logic [N_NODES-1:0] dec_nvec;
    logic [N_NODES-1:0] dec_inv;
    logic               dec_finv;
    logic               dec_wbok;

    logic               own_found;
    logic [NW-1:0]      own_idx;
    logic               inv_found;
    logic [NW-1:0]      inv_idx;

    logic               accept;
    logic               inv_fire;
    logic               ack_fire;
    logic               ack_hit;
    logic               data_hit;
    logic               last_inv;
    logic [CW-1:0]      pend_cnt;
    logic               pend_zero;

    dirc_store #(
        .N_NODES (N_NODES),
        .N_BLOCKS(N_BLOCKS),
        .AW      (AW)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(req_addr),
        .rd_st  (rd_st),
        .rd_vec (rd_vec),
        .wr_en  (wr_en),
        .wr_addr(t_addr),
        .wr_st  (wr_st),
        .wr_vec (wr_vec)
    );

    dirc_pick #(.N(N_NODES), .IW(NW)) u_owner_pick (
        .vec  (rd_vec),
        .found(own_found),
        .idx  (own_idx)
    );

    dirc_pick #(.N(N_NODES), .IW(NW)) u_inv_pick (
        .vec  (inv_left_q),
        .found(inv_found),
        .idx  (inv_idx)
    );

    dirc_tally #(.MAXC(N_NODES), .CW(CW)) u_tally (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (inv_fire),
        .dec  (ack_hit),
        .count(pend_cnt),
        .zero (pend_zero)
    );

    assign accept   = (st_q == S_IDLE) && req_valid;
    assign inv_fire = (st_q == S_INV) && msg_ready;
    assign ack_fire = ack_valid && ack_ready;
    assign ack_hit  = ack_fire && (ack_kind == AK_INV) && (ack_addr == t_addr);
    assign data_hit = (st_q == S_WAIT_DATA) && ack_fire && (ack_kind == AK_DATA)
                      && (ack_node == owner_q) && (ack_addr == t_addr);
    assign last_inv = ((inv_left_q & (inv_left_q - 1'b1)) == '0);

    // request decode against the looked-up entry
    always_comb begin
        req_oh   = N_NODES'(1) << req_node;
        dec_fsm  = S_REPLY;
        dec_nst  = DS_SHR;
        dec_nvec = rd_vec | req_oh;
        dec_inv  = '0;
        dec_finv = 1'b0;
        dec_wbok = 1'b0;
        case (req_kind)
            RQ_READ: begin
                if (rd_st == DS_MOD) begin
                    dec_fsm = S_FETCH;
                end
            end
            RQ_WRITE: begin
                dec_nst  = DS_MOD;
                dec_nvec = req_oh;
                if (rd_st == DS_MOD) begin
                    dec_fsm  = S_FETCH;
                    dec_finv = 1'b1;
                end else if (rd_st == DS_SHR) begin
                    dec_inv = rd_vec & ~req_oh;
                    if (dec_inv != '0) begin
                        dec_fsm = S_INV;
                    end
                end
            end
            default: begin
                dec_fsm  = S_WB;
                dec_nst  = DS_INV;
                dec_nvec = '0;
                dec_wbok = (req_kind == RQ_WBACK) && (rd_st == DS_MOD) && (rd_vec == req_oh);
            end
        endcase
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:      if (req_valid) st_d = dec_fsm;
            S_INV:       if (msg_ready && last_inv) st_d = S_WAIT_ACK;
            S_WAIT_ACK:  if (pend_zero) st_d = S_REPLY;
            S_FETCH:     if (msg_ready) st_d = S_WAIT_DATA;
            S_WAIT_DATA: if (data_hit) st_d = S_REPLY;
            S_REPLY:     if (msg_ready) st_d = S_IDLE;
            S_WB:        st_d = S_IDLE;
            default:     st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transaction record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_node     <= '0;
            t_addr     <= '0;
            nxt_st_q   <= DS_INV;
            nxt_vec_q  <= '0;
            inv_left_q <= '0;
            finv_q     <= 1'b0;
            wbok_q     <= 1'b0;
            owner_q    <= '0;
        end else if (accept) begin
            t_node     <= req_node;
            t_addr     <= req_addr;
            nxt_st_q   <= dec_nst;
            nxt_vec_q  <= dec_nvec;
            inv_left_q <= dec_inv;
            finv_q     <= dec_finv;
            wbok_q     <= dec_wbok;
            owner_q    <= own_idx;
        end else if (inv_fire) begin
            inv_left_q[inv_idx] <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        ack_ready    = 1'b0;
        msg_valid    = 1'b0;
        msg_node     = t_node;
        msg_kind     = OM_DATA;
        mem_wr_valid = 1'b0;
        wr_en        = 1'b0;
        wr_st        = nxt_st_q;
        wr_vec       = nxt_vec_q;
        unique case (st_q)
            S_IDLE: req_ready = 1'b1;
            S_INV: begin
                ack_ready = 1'b1;
                msg_valid = 1'b1;
                msg_node  = inv_idx;
                msg_kind  = OM_INV;
            end
            S_WAIT_ACK: ack_ready = 1'b1;
            S_FETCH: begin
                msg_valid = 1'b1;
                msg_node  = owner_q;
                msg_kind  = finv_q ? OM_FETCH_INV : OM_FETCH;
            end
            S_WAIT_DATA: begin
                ack_ready    = 1'b1;
                mem_wr_valid = data_hit;
            end
            S_REPLY: begin
                msg_valid = 1'b1;
                wr_en     = msg_ready;
            end
            S_WB: begin
                mem_wr_valid = wbok_q;
                wr_en        = wbok_q;
            end
            default: ;
        endcase
    end

    assign msg_addr    = t_addr;
    assign mem_wr_addr = t_addr;

    assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_node)
                                      && $stable(msg_addr) && $stable(msg_kind));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_zero |-> !req_ready);

    assert_no_self_inv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == OM_INV) |-> (msg_node != t_node));

    assert_reply_after_acks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == OM_DATA) |-> pend_zero);

    assert_inv_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_INV) |-> inv_found);

    assert_fetch_has_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && rd_st == DS_MOD) |-> own_found);
endmodule

// File: tb/tb_dir_home_ctrl.sv
`timescale 1ns/100ps
module tb_dir_home_ctrl;
    localparam int NN = 8;
    localparam int NB = 16;
    localparam int NW = 3;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [NW-1:0] req_node = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = '0;
    logic          ack_valid = 1'b0;
    logic          ack_ready;
    logic [NW-1:0] ack_node = '0;
    logic [AW-1:0] ack_addr = '0;
    logic          ack_kind = 1'b0;
    logic          msg_valid;
    logic          msg_ready = 1'b1;
    logic [NW-1:0] msg_node;
    logic [AW-1:0] msg_addr;
    logic [1:0]    msg_kind;
    logic          mem_wr_valid;
    logic [AW-1:0] mem_wr_addr;

    dir_home_ctrl #(.N_NODES(NN), .N_BLOCKS(NB)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_node(req_node),
        .req_addr(req_addr), .req_kind(req_kind),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_node(ack_node),
        .ack_addr(ack_addr), .ack_kind(ack_kind),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_node(msg_node),
        .msg_addr(msg_addr), .msg_kind(msg_kind),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference directory
    int          m_st [NB];
    bit [NN-1:0] m_vec [NB];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int low_bit(input bit [NN-1:0] v);
        for (int i = 0; i < NN; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic run_req(input int node, input int addr, input int kind);
        bit [NN-1:0] oh = NN'(1) << node;
        bit [NN-1:0] e_inv = '0;
        int e_fk = -1, e_fn = 0, e_mem = 0;
        bit e_rep = (kind != 2);
        string tag;
        bit [NN-1:0] r_inv = '0;
        int r_invc = 0, r_fk = -1, r_fn = 0, r_mem = 0, r_rep = 0, r_rn = 0;
        int bad_addr = 0, leak = 0, hold_bad = 0, n = 0, post = 0;
        int aq [NN + 1];
        int aq_n = 0, aq_h = 0;
        bit fpend = 0, accepted = 0, probe = 0, done = 0;
        bit stall = 0;
        logic [NW-1:0] s_node;
        logic [1:0] s_kind;

        // expected result from the model
        if (kind == 0) begin
            if (m_st[addr] == 2) begin
                tag = "R3"; e_fk = 2; e_fn = low_bit(m_vec[addr]); e_mem = 1;
            end else tag = "R2";
            m_vec[addr] = m_vec[addr] | oh; m_st[addr] = 1;
        end else if (kind == 1) begin
            if (m_st[addr] == 2) begin
                tag = "R6"; e_fk = 3; e_fn = low_bit(m_vec[addr]); e_mem = 1;
            end else if (m_st[addr] == 1) begin
                tag = "R5"; e_inv = m_vec[addr] & ~oh;
            end else tag = "R4";
            m_st[addr] = 2; m_vec[addr] = oh;
        end else begin
            if (m_st[addr] == 2 && m_vec[addr] == oh) begin
                tag = "R7"; e_mem = 1; m_st[addr] = 0; m_vec[addr] = '0;
            end else tag = "R8";
        end

        @(negedge clk);
        req_valid = 1; req_node = NW'(node); req_addr = AW'(addr); req_kind = 2'(kind);
        while (1) begin
            #1;
            if (!accepted) begin
                if (req_ready) accepted = 1;
            end else begin
                if (probe && req_ready) leak++;
                if (kind == 2) begin
                    post++;
                    if (post >= 2) done = 1;
                end
            end
            if (stall && !(msg_valid && msg_node == s_node && msg_kind == s_kind
                           && msg_addr == AW'(addr))) hold_bad++;
            stall = msg_valid && !msg_ready;
            s_node = msg_node; s_kind = msg_kind;
            if (msg_valid && msg_ready) begin
                if (msg_addr != AW'(addr)) bad_addr++;
                case (msg_kind)
                    2'd1: begin
                        r_inv[msg_node] = 1; r_invc++;
                        if (aq_n < NN + 1) begin aq[aq_n] = int'(msg_node); aq_n++; end
                    end
                    2'd2, 2'd3: begin
                        r_fk = int'(msg_kind); r_fn = int'(msg_node); fpend = 1;
                    end
                    default: begin
                        r_rep = 1; r_rn = int'(msg_node); done = 1;
                    end
                endcase
            end
            if (ack_valid && ack_ready) begin
                if (ack_kind) fpend = 0;
                else aq_h++;
            end
            if (mem_wr_valid) begin
                r_mem++;
                if (mem_wr_addr != AW'(addr)) bad_addr++;
            end
            @(negedge clk);
            n++;
            if (done || n >= 300) begin
                req_valid = 0; ack_valid = 0; msg_ready = 1;
                break;
            end
            if (accepted && !probe) begin
                if (kind == 2) req_valid = 0;
                else begin
                    probe = 1;
                    req_node = NW'((node + 1) % NN); req_kind = 2'd0;
                end
            end
            msg_ready = ((cyc % 5) != 3);
            ack_addr  = AW'(addr);
            if (fpend) begin
                ack_valid = ((cyc % 3) != 1); ack_kind = 1; ack_node = NW'(r_fn);
            end else if (aq_h < aq_n) begin
                ack_valid = ((cyc % 3) != 1); ack_kind = 0; ack_node = NW'(aq[aq_h]);
            end else ack_valid = 0;
        end

        check(n < 300, tag, "transaction finished (cycles)", n, 300);
        check(r_inv == e_inv, tag, "invalidate set", int'(r_inv), int'(e_inv));
        check(r_invc == $countones(e_inv), "R5", "invalidate count", r_invc, $countones(e_inv));
        check(r_fk == e_fk, tag, "fetch kind", r_fk, e_fk);
        if (e_fk >= 0) check(r_fn == e_fn, tag, "fetch target", r_fn, e_fn);
        check(r_mem == e_mem, tag, "memory writes", r_mem, e_mem);
        check(r_rep == int'(e_rep), tag, "reply sent", r_rep, int'(e_rep));
        if (e_rep) check(r_rn == node, tag, "reply target", r_rn, node);
        check(bad_addr == 0, tag, "address mismatches", bad_addr, 0);
        check(leak == 0, "R9", "requests taken while busy", leak, 0);
        check(hold_bad == 0, "R10", "stalled message changed", hold_bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_vec[b] = '0; end
        repeat (4) @(negedge clk);
        #1;
        check(req_ready == 1, "R1", "req_ready in reset", int'(req_ready), 1);
        rst_n = 1;
        @(negedge clk); #1;
        check(req_ready == 1, "R1", "req_ready after reset", int'(req_ready), 1);
        check(msg_valid == 0, "R1", "msg_valid after reset", int'(msg_valid), 0);
        check(ack_ready == 0, "R1", "ack_ready after reset", int'(ack_ready), 0);
        check(mem_wr_valid == 0, "R1", "mem_wr_valid after reset", int'(mem_wr_valid), 0);

        // directed: full sharer set, then ownership moves
        for (int k = 0; k < NN; k++) run_req(k, 3, 0);  // R2
        run_req(2, 3, 1);   // R5: seven invalidates
        run_req(5, 3, 1);   // R6
        run_req(1, 3, 0);   // R3
        run_req(5, 3, 2);   // R8: block is Shared
        run_req(1, 3, 1);   // R5: one invalidate to node 5
        run_req(4, 3, 2);   // R8: not the owner
        run_req(1, 3, 2);   // R7
        run_req(6, 3, 1);   // R4
        run_req(0, 9, 0);   // R2
        run_req(0, 9, 1);   // sole sharer writes: no invalidate

        // sweep across blocks, nodes and request kinds
        for (int i = 0; i < 800; i++) begin
            int a = (i * 7) % NB;
            int nd = (i * 3 + i / NB) % NN;
            int k = (i * 11 + i / 7) % 5;
            int kd = (k < 2) ? 0 : (k < 4) ? 1 : 2;
            if (kd == 2 && (i % 2) == 1 && m_st[a] == 2) nd = low_bit(m_vec[a]);
            run_req(nd, a, kd);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule